// File: doc/BRIEF.md
# Programmable Countdown Interrupt Timer

The block is a countdown timer. Software sets it up through a small set of memory-mapped registers. A write to the initial-count register loads the counter and starts it. The counter then steps down once per divided bus-clock period. The divide ratio comes from a three-bit encoded field. The ratio is a power of two from 2 to 128, or 1 for the all-ones code.

When the count runs out, the timer can raise a one-cycle interrupt request, carrying an 8-bit vector taken from its control entry. The control entry also holds a mask flag and a periodic flag. In periodic mode the counter reloads and keeps running. In one-shot mode it parks at zero. A masked expiry raises no request, but the counter still reloads or stops in the same way.

Prioritising, accepting and acknowledging the interrupt belong to other blocks. This block only produces the request pulse and its vector.

Top module: `cdown_timer`

## Requirements
- R1: After reset the control entry reads 0x0001_0000 (mask set, one-shot, vector 0). The initial count, the current count and the divide field read 0, and `irq_pulse` is low.
- R2: Register offsets are 0x320 (control entry), 0x380 (initial count), 0x390 (current count) and 0x3E0 (divide field). The control entry reads back only bits 7:0 (vector), bit 16 (mask) and bit 17 (periodic). The divide field reads back only bits 3, 1 and 0. An unmapped offset reads 0.
- R3: The current count at 0x390 is read-only. A write there changes neither the current count nor the initial count.
- R4: The divide code {bit3,bit1,bit0} maps 000→2, 001→4, 010→8, 011→16, 100→32, 101→64, 110→128 and 111→1. The counter steps down once every ratio bus clocks.
- R5: A nonzero initial-count write loads the counter and starts it. Expiry happens on the clock edge init×ratio cycles after the write edge. `irq_pulse` is then high for exactly one cycle, and `irq_vector` equals entry bits 7:0.
- R6: In one-shot mode (bit 17 = 0) the counter stays at zero after expiry. No further request follows until the initial count is written again.
- R7: In periodic mode (bit 17 = 1) the counter reloads the initial count at expiry. Requests then repeat every init×ratio cycles, and the current count never reads 0 while running.
- R8: With the mask bit (bit 16) set, no request is raised. Reload and stop behaviour stay unchanged.
- R9: Writing an initial count of 0 stops the timer with the current count at 0 and no request.
- R10: Rewriting the initial count while counting restarts from the new value, with the divider phase cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | VEC_W | Vector delivered with the request |

## Verification
Readback is combinational, so it is sampled shortly after the address changes. A request is due init×ratio clocks after the edge that takes the initial-count write, and is visible during the following cycle. The bench drives every input on the falling edge and counts falling edges from the end of the write. A request must therefore appear on exactly the init×ratio-th falling edge, and must be gone on the next one. The sweep covers every divide code with several initial counts, and the periodic intervals are measured from one request to the next in the same way.

// File: rtl/cdt_pkg.sv
`timescale 1ns/1ps
package cdt_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_ENTRY = 12'h320;
  localparam logic [ADDR_W-1:0] OFS_INIT  = 12'h380;
  localparam logic [ADDR_W-1:0] OFS_CUR   = 12'h390;
  localparam logic [ADDR_W-1:0] OFS_DIV   = 12'h3E0;

  localparam int unsigned MASK_BIT = 16;
  localparam int unsigned PER_BIT  = 17;
  localparam int unsigned MAX_DIV  = 128;

  // Packs the three scattered divide bits into one code.
  function automatic logic [2:0] div_field(input logic [DATA_W-1:0] w);
    return {w[3], w[1], w[0]};
  endfunction

  // Ratio for a divide code: all ones means 1, otherwise 2 shifted by the code.
  function automatic int unsigned div_ratio(input logic [2:0] c);
    return (c == 3'b111) ? 32'd1 : (32'd2 << c);
  endfunction
endpackage

// File: rtl/cdt_regs.sv
`timescale 1ns/1ps
module cdt_regs
  import cdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned VEC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cur,
  output logic [VEC_W-1:0]  vector,
  output logic              masked,
  output logic              periodic,
  output logic [CNT_W-1:0]  init_val,
  output logic [2:0]        div_code,
  output logic              load_evt,
  output logic [DATA_W-1:0] rdata
);
  logic entry_we, div_we;

  assign entry_we = wr_en && (addr == OFS_ENTRY);
  assign div_we   = wr_en && (addr == OFS_DIV);
  assign load_evt = wr_en && (addr == OFS_INIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vector   <= '0;
      masked   <= 1'b1;
      periodic <= 1'b0;
      init_val <= '0;
      div_code <= 3'b000;
    end else begin
      if (entry_we) begin
        vector   <= wdata[VEC_W-1:0];
        masked   <= wdata[MASK_BIT];
        periodic <= wdata[PER_BIT];
      end
      if (div_we)   div_code <= div_field(wdata);
      if (load_evt) init_val <= wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_ENTRY: begin
        rdata[VEC_W-1:0] = vector;
        rdata[MASK_BIT]  = masked;
        rdata[PER_BIT]   = periodic;
      end
      OFS_INIT: rdata = DATA_W'(init_val);
      OFS_CUR:  rdata = DATA_W'(cur);
      OFS_DIV: begin
        rdata[3] = div_code[2];
        rdata[1] = div_code[1];
        rdata[0] = div_code[0];
      end
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/cdt_prescaler.sv
`timescale 1ns/1ps
module cdt_prescaler
  import cdt_pkg::*;
#(
  parameter int unsigned PRE_W = $clog2(MAX_DIV)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       run,
  input  logic [2:0] code,
  output logic       tick
);
  logic [PRE_W-1:0] phase;
  logic [PRE_W-1:0] lim;
  logic             wrap;

  assign lim  = PRE_W'(div_ratio(code) - 32'd1);
  // >= keeps a shrinking ratio from overrunning the phase.
  assign wrap = (phase >= lim);
  assign tick = run && !clear && wrap;

  always_ff @(posedge clk) begin
    if (!rst_n)             phase <= '0;
    else if (clear || !run) phase <= '0;
    else if (wrap)          phase <= '0;
    else                    phase <= phase + 1'b1;
  end
endmodule

// File: rtl/cdt_counter.sv
`timescale 1ns/1ps
module cdt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             tick,
  input  logic             periodic,
  output logic [CNT_W-1:0] cur,
  output logic             running,
  output logic             expire
);
  assign expire = tick && (cur == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur     <= '0;
      running <= 1'b0;
    end else if (load) begin
      cur     <= load_val;
      running <= (load_val != '0);
    end else if (expire) begin
      if (periodic) begin
        cur <= reload_val;
      end else begin
        cur     <= '0;
        running <= 1'b0;
      end
    end else if (tick) begin
      cur <= cur - 1'b1;
    end
  end
endmodule

// File: rtl/cdown_timer.sv
`timescale 1ns/1ps
module cdown_timer
  import cdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned VEC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [11:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_pulse,
  output logic [VEC_W-1:0]  irq_vector
);
  logic [VEC_W-1:0] vector;
  logic             masked, periodic;
  logic [CNT_W-1:0] init_val, cur;
  logic [2:0]       div_code;
  logic             load_evt, tick_evt, expire_evt, running;

  cdt_regs #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .cur(cur), .vector(vector), .masked(masked),
    .periodic(periodic), .init_val(init_val), .div_code(div_code),
    .load_evt(load_evt), .rdata(bus_rdata)
  );

  cdt_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .clear(load_evt), .run(running),
    .code(div_code), .tick(tick_evt)
  );

  cdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load_evt),
    .load_val(bus_wdata[CNT_W-1:0]), .reload_val(init_val),
    .tick(tick_evt), .periodic(periodic), .cur(cur),
    .running(running), .expire(expire_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_pulse  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_pulse <= expire_evt && !masked;
      if (expire_evt && !masked) irq_vector <= vector;
    end
  end
endmodule

// File: rtl/cdown_timer_checker.sv
`timescale 1ns/1ps
module cdown_timer_checker #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_evt,
  input logic             tick_evt,
  input logic             expire_evt,
  input logic             masked,
  input logic             periodic,
  input logic             running,
  input logic [CNT_W-1:0] cur,
  input logic [CNT_W-1:0] init_val,
  input logic             irq_pulse
);
  assert_pulse_after_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(expire_evt));

  assert_masked_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && masked) |=> !irq_pulse);

  assert_tick_only_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_evt |-> running);

  assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_evt && !load_evt && !expire_evt) |=> (cur == CNT_W'($past(cur) - 1'b1)));

  assert_oneshot_park_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && !periodic && !load_evt) |=> (cur == '0 && !running));

  assert_stopped_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !load_evt) |=> ($stable(cur) && !running));

  assert_periodic_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && periodic && !load_evt) |=> (cur == $past(init_val)));

  assert_running_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cur != '0));
endmodule

bind cdown_timer cdown_timer_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_evt(load_evt), .tick_evt(tick_evt),
  .expire_evt(expire_evt), .masked(masked), .periodic(periodic),
  .running(running), .cur(cur), .init_val(init_val), .irq_pulse(irq_pulse)
);

// File: tb/cdown_timer_bench.sv
`timescale 1ns/1ps
module cdown_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_pulse;
  logic [7:0]  irq_vector;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  localparam logic [11:0] A_ENTRY = 12'h320, A_INIT = 12'h380,
                          A_CUR = 12'h390, A_DIV = 12'h3E0;

  cdown_timer u_cdown_timer (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pulse(irq_pulse), .irq_vector(irq_vector)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic int ratio_of(input int code);
    return (code == 7) ? 1 : (1 << (code + 1));
  endfunction

  function automatic logic [31:0] div_word(input int code);
    logic [2:0] c = 3'(code);
    return {28'd0, c[2], 1'b0, c[1], c[0]};
  endfunction

  function automatic logic [31:0] entry_word(input logic [7:0] vec, input bit msk, input bit per);
    return {14'd0, per, msk, 8'd0, vec};
  endfunction

  // Counts falling edges until a request is seen; lat = -1 if none within limit.
  task automatic wait_pulse(input int limit, output int lat, output logic [7:0] vec);
    int k = 0;
    lat = -1;
    vec = '0;
    while (lat < 0 && k < limit) begin
      @(negedge clk);
      k++;
      if (irq_pulse) begin
        lat = k;
        vec = irq_vector;
      end
    end
  endtask

  task automatic count_pulses(input int n, output int cnt);
    cnt = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (irq_pulse) cnt++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  v;
    int lat, cnt;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_ENTRY, d); check("R1", "entry after reset", d, 32'h0001_0000);
    rd(A_INIT, d);  check("R1", "init after reset", d, 0);
    rd(A_CUR, d);   check("R1", "current after reset", d, 0);
    rd(A_DIV, d);   check("R1", "divide after reset", d, 0);
    check("R1", "pulse after reset", {31'd0, irq_pulse}, 0);

    // R2 readback field masks
    wr(A_ENTRY, 32'hFFFF_FFFF); rd(A_ENTRY, d); check("R2", "entry readback", d, 32'h0003_00FF);
    wr(A_DIV, 32'hFFFF_FFFF);   rd(A_DIV, d);   check("R2", "divide readback", d, 32'h0000_000B);
    wr(A_INIT, 32'd0);          rd(A_INIT, d);  check("R2", "init readback", d, 0);
    rd(12'h100, d); check("R2", "unmapped read", d, 0);

    // R3 current count is read-only
    wr(A_CUR, 32'd77);
    rd(A_CUR, d);  check("R3", "current after write", d, 0);
    rd(A_INIT, d); check("R3", "init after current write", d, 0);

    // R4/R5/R6 sweep over every divide code and several counts
    for (int code = 0; code < 8; code++) begin
      for (int init = 1; init <= 3; init++) begin
        logic [7:0] vexp = 8'(8'h10 + code * 4 + init);
        wr(A_ENTRY, entry_word(vexp, 1'b0, 1'b0));
        wr(A_DIV, div_word(code));
        wr(A_INIT, 32'(init));
        wait_pulse(600, lat, v);
        check("R4", $sformatf("latency code=%0d init=%0d", code, init),
              32'(lat), 32'(init * ratio_of(code)));
        check("R5", "vector with request", {24'd0, v}, {24'd0, vexp});
        @(negedge clk);
        check("R5", "request lasts one cycle", {31'd0, irq_pulse}, 0);
        rd(A_CUR, d); check("R6", "one-shot parks at zero", d, 0);
      end
    end

    // R6 no further requests after a one-shot expiry
    count_pulses(60, cnt);
    check("R6", "pulses after one-shot", 32'(cnt), 0);
    rd(A_CUR, d); check("R6", "current stays zero", d, 0);

    // R7 periodic, divide by 1
    wr(A_ENTRY, entry_word(8'h41, 1'b0, 1'b1));
    wr(A_DIV, div_word(7));
    wr(A_INIT, 32'd5);
    wait_pulse(100, lat, v); check("R7", "first period", 32'(lat), 5);
    wait_pulse(100, lat, v); check("R7", "second period", 32'(lat), 5);
    check("R7", "periodic vector", {24'd0, v}, 32'h41);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      rd(A_CUR, d);
      if (d == 0) check("R7", "current nonzero while periodic", d, 1);
    end
    wait_pulse(100, lat, v); checks++;
    if (lat < 1 || lat > 5) begin
      errors++;
      $display("FAIL R7 third period actual=%0d expected=1..5", lat);
    end

    // R9 zero initial count stops a running timer
    wr(A_INIT, 32'd0);
    count_pulses(40, cnt);
    check("R9", "pulses after zero init", 32'(cnt), 0);
    rd(A_CUR, d); check("R9", "current after zero init", d, 0);

    // R7 periodic, divide by 2
    wr(A_DIV, div_word(0));
    wr(A_INIT, 32'd3);
    wait_pulse(100, lat, v); check("R7", "period div2 first", 32'(lat), 6);
    wait_pulse(100, lat, v); check("R7", "period div2 second", 32'(lat), 6);

    // R8 masked periodic still reloads
    wr(A_ENTRY, entry_word(8'h55, 1'b1, 1'b1));
    wr(A_DIV, div_word(7));
    wr(A_INIT, 32'd4);
    count_pulses(30, cnt);
    check("R8", "pulses while masked", 32'(cnt), 0);
    rd(A_CUR, d); checks++;
    if (d < 1 || d > 4) begin
      errors++;
      $display("FAIL R8 current while masked actual=%0d expected=1..4", d);
    end
    wr(A_ENTRY, entry_word(8'h55, 1'b0, 1'b1));
    wait_pulse(10, lat, v); checks++;
    if (lat < 1 || lat > 4) begin
      errors++;
      $display("FAIL R8 reload after unmask actual=%0d expected=1..4", lat);
    end
    check("R8", "vector after unmask", {24'd0, v}, 32'h55);

    // R8 masked one-shot: no request, counter still parks
    wr(A_ENTRY, entry_word(8'h66, 1'b1, 1'b0));
    wr(A_INIT, 32'd3);
    count_pulses(20, cnt);
    check("R8", "masked one-shot pulses", 32'(cnt), 0);
    rd(A_CUR, d); check("R8", "masked one-shot parks", d, 0);

    // R10 restart mid-count with a new value and cleared divider phase
    wr(A_ENTRY, entry_word(8'h77, 1'b0, 1'b0));
    wr(A_DIV, div_word(1));
    wr(A_INIT, 32'd100);
    repeat (7) @(negedge clk);
    wr(A_INIT, 32'd2);
    wait_pulse(500, lat, v);
    check("R10", "latency after restart", 32'(lat), 8);
    rd(A_INIT, d); check("R10", "init after restart", d, 2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule